// File: doc/BRIEF.md
# Flash Command and Status Controller

This block sits between a parallel host bus and the cell array of a NOR-style flash. It decodes command bytes written on the bus and runs word programming and block erasure against an abstract array port. It issues single-cycle pulse requests, samples a verify result after each pulse, and retries until verify passes or a pulse limit is reached. The limit for programming and the limit for erasure are separate parameters. A per-block lock vector and a supply-ok input can abort an operation before any pulse is issued.

The host reads an 8-bit status byte or the array data from one read port. The read mode changes with commands, and the status byte is forced onto the port while an operation is running. A running program or erase can be suspended. While it is suspended the host may read the array, and a confirm command resumes it. Error flags stay set until the host clears them. An illegal command sequence is reported with a combined error pattern.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Status byte fields:
  - bit 7: ready (1) or busy (0)
  - bit 6: erase suspended
  - bit 5: erase failure
  - bit 4: program failure
  - bit 3: supply-low abort
  - bit 2: program suspended
  - bit 1: locked-block abort
  - bit 0: always 0

  After reset the read port is in array mode, and command 0x70 selects status mode, where an idle device reads 0x80.
- R2: Command 0x40 or 0x10, followed by a data write, programs the byte at the written address. A pulse is issued, verify is sampled in the next cycle, and pulses repeat until verify passes. After MAX_PROG failed pulses, bit 4 is set.
- R3: Command 0x20 followed by 0xD0 erases the addressed block with the same retry loop. After MAX_ERASE failed pulses, bit 5 is set.
- R4: A program or erase whose address lies in a block whose bit in blockLock is 1 issues no pulse. It sets bit 1 and returns ready in status mode. The block index is the top BLK_W address bits.
- R5: vppOk is sampled once when an operation starts and again in the verify cycle after each pulse. If it is low at either point, bit 3 is set and the operation ends at once. A drop between pulses is caught at the next verify.
- R6: Either of the following sets bits 4 and 5 together with bit 7:
  - 0x20 followed by any byte other than 0xD0;
  - an unassigned code written while ready.

  0xD0 and 0xB0 written while ready with nothing suspended have no effect.
- R7: 0xB0 during an erase stops pulsing and reads as 0xC0. Bit 6 stays set, and no pulse is issued, until 0xD0 resumes the erase.
- R8: 0xB0 during a program stops pulsing and sets bits 7 and 2. Bit 2 stays set until 0xD0 resumes the program.
- R9: Bits 1, 3, 4 and 5 stay set until command 0x50 clears them, and 0x50 leaves the read mode unchanged.
- R10: While busy, the read port returns the status byte, and every write other than 0xB0 is ignored.
- R11: In array mode while not busy, the read port returns arrayRdata. Command 0xFF selects array mode, both when ready and when suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | One-cycle bus write strobe |
| busAddr | input | ADDR_W | Bus write address |
| busData | input | 8 | Bus write data or command byte |
| rdData | output | 8 | Status byte or array data |
| arrayRdata | input | 8 | Array read data |
| pulseReq | output | 1 | One-cycle program or erase pulse request |
| pulseErase | output | 1 | 1 when the current operation is an erase |
| pulseAddr | output | ADDR_W | Target address of the operation |
| pulseData | output | 8 | Data to program |
| verifyOk | input | 1 | Verify result, sampled the cycle after pulseReq |
| blockLock | input | 2**BLK_W | Per-block lock bits |
| vppOk | input | 1 | Programming supply good |

## Verification
If the mode tracker holds the wrong state, the next read shows it within one cycle. A stuck busy state shows up as bit 7 never returning. A lost suspend shows up as pulse requests during a suspension. A wrong pulse counter shows up in the number of pulses the array model counts before a failure bit appears. Error flags that are wrongly held or dropped are exposed by the read that follows the next 0x70 or 0x50 command.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RDSTAT  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_RDARRAY = 8'hFF;

  typedef enum logic [2:0] {
    ST_READY, ST_PSETUP, ST_ESETUP, ST_START, ST_PULSE, ST_CHECK, ST_SUSP
  } ctrl_state_t;

  typedef struct packed {
    logic latchProg;
    logic latchErase;
    logic cntInc;
    logic setVpp;
    logic setLock;
    logic setFail;
    logic setSeqErr;
    logic clrErr;
    logic setSusp;
    logic clrSusp;
    logic modeStatus;
    logic modeArray;
  } strobe_t;
endpackage

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BLK_W     = 2,
  parameter int MAX_PROG  = 3,
  parameter int MAX_ERASE = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic                   busy,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [7:0]             busData,
  input  logic [(1<<BLK_W)-1:0]  blockLock,
  input  logic [7:0]             arrayRdata,
  output logic [7:0]             statusByte,
  output logic [7:0]             rdData,
  output logic [ADDR_W-1:0]      opAddr,
  output logic [7:0]             opData,
  output logic                   opErase,
  output logic                   lockHit,
  output logic                   cntAtMax
);
  localparam int MAX_PULSE = (MAX_PROG > MAX_ERASE) ? MAX_PROG : MAX_ERASE;
  localparam int CNT_W     = $clog2(MAX_PULSE + 2);
  localparam logic [CNT_W-1:0] PROG_LIM  = CNT_W'(MAX_PROG);
  localparam logic [CNT_W-1:0] ERASE_LIM = CNT_W'(MAX_ERASE);

  logic [CNT_W-1:0] pulseCnt;
  logic vppLow, lockErr, progFail, eraseFail, progSusp, eraseSusp, statusMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      opAddr <= '0;
      opData <= '0;
      opErase <= 1'b0;
      vppLow <= 1'b0;
      lockErr <= 1'b0;
      progFail <= 1'b0;
      eraseFail <= 1'b0;
      progSusp <= 1'b0;
      eraseSusp <= 1'b0;
      statusMode <= 1'b0;
    end else begin
      if (strb.latchProg || strb.latchErase) begin
        opAddr <= busAddr;
        opData <= busData;
        opErase <= strb.latchErase;
        pulseCnt <= '0;
      end else if (strb.cntInc) begin
        pulseCnt <= pulseCnt + 1'b1;
      end
      if (strb.clrErr) begin
        vppLow <= 1'b0;
        lockErr <= 1'b0;
        progFail <= 1'b0;
        eraseFail <= 1'b0;
      end else begin
        if (strb.setVpp) vppLow <= 1'b1;
        if (strb.setLock) lockErr <= 1'b1;
        if (strb.setSeqErr || (strb.setFail && !opErase)) progFail <= 1'b1;
        if (strb.setSeqErr || (strb.setFail && opErase)) eraseFail <= 1'b1;
      end
      if (strb.setSusp) begin
        progSusp <= !opErase;
        eraseSusp <= opErase;
      end else if (strb.clrSusp) begin
        progSusp <= 1'b0;
        eraseSusp <= 1'b0;
      end
      if (strb.modeStatus) statusMode <= 1'b1;
      else if (strb.modeArray) statusMode <= 1'b0;
    end
  end

  assign lockHit = blockLock[opAddr[ADDR_W-1 -: BLK_W]];
  assign cntAtMax = pulseCnt >= (opErase ? ERASE_LIM : PROG_LIM);
  assign statusByte = {!busy, eraseSusp, eraseFail, progFail, vppLow, progSusp, lockErr, 1'b0};
  assign rdData = (statusMode || busy) ? statusByte : arrayRdata;
endmodule

// File: rtl/flash_cmd_control.sv
module flash_cmd_control
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [7:0] busData,
  input  logic       vppOk,
  input  logic       verifyOk,
  input  logic       lockHit,
  input  logic       cntAtMax,
  output strobe_t    strb,
  output logic       busy,
  output logic       pulseReq
);
  ctrl_state_t state, stateNext;
  logic suspCmd;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_READY;
    else state <= stateNext;
  end

  assign busy = (state == ST_START) || (state == ST_PULSE) || (state == ST_CHECK);
  assign suspCmd = busWe && (busData == CMD_SUSPEND);

  always_comb begin
    stateNext = state;
    strb = '0;
    pulseReq = 1'b0;
    unique case (state)
      ST_READY: if (busWe) begin
        unique case (busData)
          CMD_PROG, CMD_PROG_ALT: begin stateNext = ST_PSETUP; strb.modeStatus = 1'b1; end
          CMD_ERASE:   begin stateNext = ST_ESETUP; strb.modeStatus = 1'b1; end
          CMD_RDSTAT:  strb.modeStatus = 1'b1;
          CMD_RDARRAY: strb.modeArray = 1'b1;
          CMD_CLEAR:   strb.clrErr = 1'b1;
          CMD_CONFIRM, CMD_SUSPEND: ;
          default: begin strb.setSeqErr = 1'b1; strb.modeStatus = 1'b1; end
        endcase
      end
      ST_PSETUP: if (busWe) begin
        strb.latchProg = 1'b1;
        strb.modeStatus = 1'b1;
        stateNext = ST_START;
      end
      ST_ESETUP: if (busWe) begin
        strb.modeStatus = 1'b1;
        if (busData == CMD_CONFIRM) begin
          strb.latchErase = 1'b1;
          stateNext = ST_START;
        end else begin
          strb.setSeqErr = 1'b1;
          stateNext = ST_READY;
        end
      end
      ST_START:
        if (suspCmd) begin strb.setSusp = 1'b1; stateNext = ST_SUSP; end
        else if (!vppOk) begin strb.setVpp = 1'b1; stateNext = ST_READY; end
        else if (lockHit) begin strb.setLock = 1'b1; stateNext = ST_READY; end
        else stateNext = ST_PULSE;
      ST_PULSE:
        if (suspCmd) begin strb.setSusp = 1'b1; stateNext = ST_SUSP; end
        else begin pulseReq = 1'b1; strb.cntInc = 1'b1; stateNext = ST_CHECK; end
      ST_CHECK:
        if (suspCmd) begin strb.setSusp = 1'b1; stateNext = ST_SUSP; end
        else if (!vppOk) begin strb.setVpp = 1'b1; stateNext = ST_READY; end
        else if (verifyOk) stateNext = ST_READY;
        else if (cntAtMax) begin strb.setFail = 1'b1; stateNext = ST_READY; end
        else stateNext = ST_PULSE;
      ST_SUSP: if (busWe) begin
        unique case (busData)
          CMD_CONFIRM: begin strb.clrSusp = 1'b1; strb.modeStatus = 1'b1; stateNext = ST_START; end
          CMD_RDSTAT:  strb.modeStatus = 1'b1;
          CMD_RDARRAY: strb.modeArray = 1'b1;
          CMD_CLEAR:   strb.clrErr = 1'b1;
          default: ;
        endcase
      end
      default: stateNext = ST_READY;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BLK_W     = 2,
  parameter int MAX_PROG  = 3,
  parameter int MAX_ERASE = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [7:0]            busData,
  output logic [7:0]            rdData,
  input  logic [7:0]            arrayRdata,
  output logic                  pulseReq,
  output logic                  pulseErase,
  output logic [ADDR_W-1:0]     pulseAddr,
  output logic [7:0]            pulseData,
  input  logic                  verifyOk,
  input  logic [(1<<BLK_W)-1:0] blockLock,
  input  logic                  vppOk
);
  strobe_t strb;
  logic busy, lockHit, cntAtMax;
  logic [7:0] statusByte;

  flash_cmd_control u_control (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busData(busData),
    .vppOk(vppOk), .verifyOk(verifyOk), .lockHit(lockHit), .cntAtMax(cntAtMax),
    .strb(strb), .busy(busy), .pulseReq(pulseReq)
  );

  flash_cmd_datapath #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .MAX_PROG(MAX_PROG), .MAX_ERASE(MAX_ERASE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .busAddr(busAddr),
    .busData(busData), .blockLock(blockLock), .arrayRdata(arrayRdata),
    .statusByte(statusByte), .rdData(rdData), .opAddr(pulseAddr),
    .opData(pulseData), .opErase(pulseErase), .lockHit(lockHit), .cntAtMax(cntAtMax)
  );
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busWe,
  input logic [7:0] busData,
  input logic       pulseReq,
  input logic [7:0] statusByte
);
  p_bit0_zero_r1: assert property (@(posedge clk) disable iff (!rstN) statusByte[0] == 1'b0);
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rstN) pulseReq |=> !pulseReq);
  p_pulse_busy_r10: assert property (@(posedge clk) disable iff (!rstN) pulseReq |-> !statusByte[7]);
  p_susp_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] || statusByte[2]) |-> (statusByte[7] && !pulseReq));
  p_susp_excl_r8: assert property (@(posedge clk) disable iff (!rstN) !(statusByte[6] && statusByte[2]));
  p_esusp_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[6]) |-> $past(busWe && busData == 8'hB0));
  p_psusp_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[2]) |-> $past(busWe && busData == 8'hB0));
  p_vpp_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[3]) |-> $past(busWe && busData == 8'h50));
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(statusByte[4]) || $fell(statusByte[5]) || $fell(statusByte[1]))
      |-> $past(busWe && busData == 8'h50));
endmodule

bind flash_cmd_ctrl flash_cmd_checker u_checker (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busData(busData),
  .pulseReq(pulseReq), .statusByte(statusByte)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int ADDR_W = 8;
  localparam int BLK_W = 2;
  localparam int MAXP = 3;
  localparam int MAXE = 5;

  logic clk = 1'b0;
  logic rstN, busWe, vppOk, verifyOk, pulseReq, pulseErase;
  logic [ADDR_W-1:0] busAddr, pulseAddr;
  logic [7:0] busData, rdData, arrayRdata, pulseData;
  logic [(1<<BLK_W)-1:0] blockLock;
  int checks = 0, errors = 0, pcount = 0, pbase = 0, need = 1;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .MAX_PROG(MAXP), .MAX_ERASE(MAXE)) u_flash_cmd_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busData(busData),
    .rdData(rdData), .arrayRdata(arrayRdata), .pulseReq(pulseReq), .pulseErase(pulseErase),
    .pulseAddr(pulseAddr), .pulseData(pulseData), .verifyOk(verifyOk),
    .blockLock(blockLock), .vppOk(vppOk)
  );

  // array model: verify passes once 'need' pulses have landed since pbase
  always @(posedge clk) if (pulseReq) pcount <= pcount + 1;
  assign verifyOk = (pcount - pbase) >= need;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busData = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic waitReady(input string req);
    for (int i = 0; i < 400; i++) begin
      if (rdData[7]) return;
      @(negedge clk);
    end
    chk({req, " timeout"}, 0, 1);
  endtask

  task automatic waitPulses(input int n);
    for (int i = 0; i < 400 && (pcount - pbase) < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rstN = 0; busWe = 0; busAddr = '0; busData = '0; vppOk = 1;
    blockLock = '0; arrayRdata = 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R11 reset array mode", rdData, 8'h5A);
    wr(8'h00, 8'h70);
    chk("R1 idle status", rdData, 8'h80);

    // R2: program sweep for both setup codes
    for (int c = 0; c < 2; c++) begin
      for (int n = 1; n <= MAXP + 1; n++) begin
        wr(8'h00, 8'h50);
        need = n; pbase = pcount;
        wr(8'h00, c == 0 ? 8'h40 : 8'h10);
        wr(8'h11 + 8'(n), 8'hC0 + 8'(n));
        waitReady("R2");
        chk("R2 program status", rdData, n <= MAXP ? 8'h80 : 8'h90);
        chk("R2 program pulses", pcount - pbase, n <= MAXP ? n : MAXP);
        chk("R2 program target", {pulseErase, pulseAddr, pulseData}, {1'b0, 8'h11 + 8'(n), 8'hC0 + 8'(n)});
      end
    end

    // R3: erase sweep
    for (int n = 1; n <= MAXE + 1; n++) begin
      wr(8'h00, 8'h50);
      need = n; pbase = pcount;
      wr(8'h44, 8'h20);
      wr(8'h44, 8'hD0);
      waitReady("R3");
      chk("R3 erase status", rdData, n <= MAXE ? 8'h80 : 8'hA0);
      chk("R3 erase pulses", pcount - pbase, n <= MAXE ? n : MAXE);
      chk("R3 erase kind", pulseErase, 1);
    end

    // R9: sticky error, then clear keeps status mode
    wr(8'h00, 8'h70);
    chk("R9 error held", rdData, 8'hA0);
    wr(8'h00, 8'h50);
    chk("R9 cleared", rdData, 8'h80);

    // R11: array mode
    wr(8'h00, 8'hFF);
    chk("R11 array read", rdData, 8'h5A);
    arrayRdata = 8'h3C;
    @(negedge clk);
    chk("R11 array follows", rdData, 8'h3C);

    // R4: locked block
    blockLock = 4'b0100;
    wr(8'h00, 8'h50);
    need = 1; pbase = pcount;
    wr(8'h00, 8'h40);
    wr(8'h85, 8'h77);
    waitReady("R4");
    chk("R4 lock program status", rdData, 8'h82);
    chk("R4 lock program pulses", pcount - pbase, 0);
    wr(8'h00, 8'h50);
    wr(8'h9A, 8'h20);
    wr(8'h9A, 8'hD0);
    waitReady("R4");
    chk("R4 lock erase status", rdData, 8'h82);
    chk("R4 lock erase pulses", pcount - pbase, 0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h40);
    wr(8'h45, 8'h12);
    waitReady("R4");
    chk("R4 unlocked block", rdData, 8'h80);
    chk("R4 unlocked pulses", pcount - pbase, 1);
    blockLock = '0;

    // R5: supply low at start
    wr(8'h00, 8'h50);
    vppOk = 0; need = 1; pbase = pcount;
    wr(8'h00, 8'h40);
    wr(8'h21, 8'h33);
    waitReady("R5");
    chk("R5 vpp start status", rdData, 8'h88);
    chk("R5 vpp start pulses", pcount - pbase, 0);
    vppOk = 1;
    // R5: supply drops before verify
    wr(8'h00, 8'h50);
    need = 1; pbase = pcount;
    wr(8'h00, 8'h40);
    wr(8'h21, 8'h33);
    for (int i = 0; i < 20 && !pulseReq; i++) @(negedge clk);
    vppOk = 0;
    waitReady("R5");
    chk("R5 vpp verify status", rdData, 8'h88);
    chk("R5 vpp verify pulses", pcount - pbase, 1);
    vppOk = 1;

    // R6: sequence errors and no-op commands
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h20);
    wr(8'h00, 8'hFF);
    chk("R6 bad confirm", rdData, 8'hB0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h33);
    chk("R6 unassigned code", rdData, 8'hB0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'hD0);
    wr(8'h00, 8'hB0);
    chk("R6 idle confirm/suspend no effect", rdData, 8'h80);

    // R7: erase suspend/resume
    wr(8'h00, 8'h50);
    need = 4; pbase = pcount;
    wr(8'h4C, 8'h20);
    wr(8'h4C, 8'hD0);
    waitPulses(2);
    wr(8'h00, 8'hB0);
    chk("R7 erase suspended", rdData, 8'hC0);
    begin
      int p1;
      p1 = pcount;
      repeat (6) @(negedge clk);
      chk("R7 no pulses while suspended", pcount, p1);
    end
    wr(8'h00, 8'hFF);
    chk("R11 array while suspended", rdData, 8'h3C);
    wr(8'h00, 8'h70);
    chk("R7 bit held", rdData, 8'hC0);
    wr(8'h00, 8'hD0);
    waitReady("R7");
    chk("R7 resumed erase done", rdData, 8'h80);
    chk("R7 resumed erase pulses", pcount - pbase, 4);

    // R8: program suspend/resume
    need = 3; pbase = pcount;
    wr(8'h00, 8'h40);
    wr(8'h30, 8'h5E);
    waitPulses(2);
    wr(8'h00, 8'hB0);
    chk("R8 program suspended", rdData, 8'h84);
    wr(8'h00, 8'hD0);
    waitReady("R8");
    chk("R8 resumed program done", rdData, 8'h80);
    chk("R8 resumed program pulses", pcount - pbase, 3);

    // R10: commands ignored while busy
    wr(8'h00, 8'h50);
    need = 5; pbase = pcount;
    wr(8'h44, 8'h20);
    wr(8'h44, 8'hD0);
    wr(8'h00, 8'hFF);
    chk("R10 status while busy", rdData, 8'h00);
    wr(8'h00, 8'h33);
    waitReady("R10");
    chk("R10 ignored writes", rdData, 8'h80);
    chk("R10 pulses unaffected", pcount - pbase, 5);

    finish_run();
  end
endmodule